// File: doc/BRIEF.md
# Prescaled Pulse and Toggle Generator

A per-pin output generator that drives one pin level from a free-running prescaler. Software writes a base period X, in system clocks, with one strobe and a count Y with another. In pulse mode the pin goes high once for Y base periods. In toggle mode the pin inverts on Y consecutive prescaler rollovers. A pin-direction enable that is active high runs the block. While that enable is low the block is held cleared.

The prescaler phase comes from the last X load. A later Y write therefore starts its output at the next rollover of that phase. An optional restart input, given with a Y write, reloads the prescaler on that same clock. Several instances can then start on aligned edges. A completion flag rises when the last period or transition ends and stays high until it is acknowledged. A busy output covers the time from the write to completion.

Top module: `pulse_burst_gen`

## Requirements
- R1: A sampled `x_load_i` stores `x_i` as the base period and zeroes the prescaler phase. If the load is sampled at edge E, pin actions may occur only at edges E+n*X with n ≥ 1. X = 0 means a period of 65536 clocks.
- R2: Pulse mode is `mode_i` = 0. A nonzero Y write sampled at edge Ey sets the pin high at the first rollover edge S > Ey. The pin stays high for Y*X clocks and returns low at edge S+Y*X. With X = 1 and Y = 1 the pin is high for exactly one clock, starting at Ey+1.
- R3: Toggle mode is `mode_i` = 1. The pin inverts at the rollover edges S, S+X, …, S+(Y-1)*X, which is exactly Y transitions. Afterwards it keeps its final level, including across later bursts.
- R4: When `restart_i` is high with a sampled Y write at Ey, the prescaler phase restarts at Ey, so the first rollover is edge Ey+X.
- R5: `busy_o` is high from the edge that samples an accepted Y write until the completion edge. It goes low on the same edge where `done_o` rises.
- R6: `done_o` rises at the completion edge: S+Y*X in pulse mode, S+(Y-1)*X in toggle mode. It stays high until `ack_i` is sampled high, and clears on that edge.
- R7: A nonzero Y write during an active pulse reloads the count at the first rollover after the write. The prescaler phase does not change. A pulse already high stays high until the new count ends.
- R8: A Y write of zero is ignored. `busy_o` stays low, the pin keeps its level and `done_o` stays low.
- R9: While `en_i` is low, the next edge clears the pin, `busy_o`, `done_o` and any pending or running count. Y writes made while `en_i` is low are ignored.
- R10: After reset the pin, `busy_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pin direction enable; low holds the block cleared |
| mode_i | input | 1 | 0 = one-shot pulse, 1 = counted toggle |
| x_load_i | input | 1 | Strobe that loads the base period and zeroes the prescaler phase |
| x_i | input | 16 | Base period in clocks (0 means 65536) |
| y_load_i | input | 1 | Strobe that loads the count |
| y_i | input | 16 | Period count (pulse) or transition count (toggle) |
| restart_i | input | 1 | With `y_load_i`, restarts the prescaler phase |
| ack_i | input | 1 | Clears the completion flag |
| pin_o | output | 1 | Pin drive level |
| done_o | output | 1 | Completion flag, held until acknowledged |
| busy_o | output | 1 | Count pending or in progress |

## Verification
Each transaction is checked cycle by cycle. The bench computes the expected pin, busy and done waveforms from the X-load edge, the Y-write edge and the restart choice, so an off-by-one in the rollover phase, the start edge or the completion edge shows up as a mismatch. Random mixes of period, count, write gap, mode and restart are run after directed cases: the one-clock pulse, a delayed start, a phase restart, a toggle burst that leaves the pin high, a retrigger during a pulse, a zero count, a disable during a burst, and the 65536-clock period. The random mixes separate phase-following starts from restarted starts. They also separate pulse timing (Y*X high) from toggle timing (Y edges). Toggle bursts that start from a level left high by an earlier burst show whether the level is held between bursts.

// File: rtl/pulse_burst_pkg.sv
package pulse_burst_pkg;
  typedef enum logic {
    MODE_PULSE  = 1'b0,
    MODE_TOGGLE = 1'b1
  } pbg_mode_e;
endpackage

// File: rtl/pbg_prescaler.sv
module pbg_prescaler #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             per_load_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             reload_i,
  output logic             tick_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cnt_q;
  logic             match;

  // per_q = 0 wraps to all ones, giving a 2**PER_W period
  assign match  = (cnt_q == (per_q - ONE));
  assign tick_o = en_i & ~reload_i & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
    end else if (per_load_i) begin
      per_q <= per_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || reload_i || match) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/pbg_sequencer.sv
module pbg_sequencer
  import pulse_burst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             tick_i,
  input  logic             y_load_i,
  input  logic [CNT_W-1:0] y_i,
  input  logic             ack_i,
  output logic             pin_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             pend_q, act_q, pin_q, done_q;
  logic [CNT_W-1:0] next_q, rem_q;
  logic             is_tgl, accept, start, step, finish;

  assign is_tgl = (mode_i == MODE_TOGGLE);
  assign accept = en_i & y_load_i & (|y_i);
  assign start  = pend_q & tick_i;
  assign step   = act_q & tick_i & ~pend_q;
  assign finish = start ? (is_tgl & (next_q == ONE)) : (step & (rem_q == ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      next_q <= '0;
      rem_q  <= '0;
    end else if (!en_i) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      next_q <= '0;
      rem_q  <= '0;
    end else begin
      if (ack_i) done_q <= 1'b0;
      if (start) begin
        pend_q <= 1'b0;
        act_q  <= ~finish;
        if (is_tgl) begin
          pin_q <= ~pin_q;
          rem_q <= next_q - ONE;
        end else begin
          pin_q <= 1'b1;
          rem_q <= next_q;
        end
      end else if (step) begin
        rem_q <= rem_q - ONE;
        if (is_tgl) pin_q <= ~pin_q;
        if (finish) begin
          act_q <= 1'b0;
          if (!is_tgl) pin_q <= 1'b0;
        end
      end
      if (finish) done_q <= 1'b1;
      // a fresh write wins over a start in the same cycle
      if (accept) begin
        pend_q <= 1'b1;
        next_q <= y_i;
      end
    end
  end

  assign pin_o  = pin_q;
  assign done_o = done_q;
  assign busy_o = pend_q | act_q;
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen #(
  parameter int PER_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             x_load_i,
  input  logic [PER_W-1:0] x_i,
  input  logic             y_load_i,
  input  logic [CNT_W-1:0] y_i,
  input  logic             restart_i,
  input  logic             ack_i,
  output logic             pin_o,
  output logic             done_o,
  output logic             busy_o
);
  logic reload, tick;

  assign reload = x_load_i | (en_i & y_load_i & restart_i);

  pbg_prescaler #(.PER_W(PER_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .per_load_i (x_load_i),
    .per_i      (x_i),
    .reload_i   (reload),
    .tick_o     (tick)
  );

  pbg_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mode_i   (mode_i),
    .tick_i   (tick),
    .y_load_i (y_load_i),
    .y_i      (y_i),
    .ack_i    (ack_i),
    .pin_o    (pin_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );
endmodule

// File: rtl/pulse_burst_gen_chk.sv
module pulse_burst_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic y_load_i,
  input logic ack_i,
  input logic pin_o,
  input logic done_o,
  input logic busy_o
);
  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pin_o && !busy_o && !done_o));

  a_r5_busy_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(y_load_i));

  a_r6_done_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_o) && !busy_o));

  a_r6_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i && en_i) |=> done_o);

  // R2, R3: the pin moves only while a count is pending or running
  a_r3_pin_moves_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o != $past(pin_o)) && $past(en_i)) |-> $past(busy_o));
endmodule

bind pulse_burst_gen pulse_burst_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .y_load_i (y_load_i),
  .ack_i    (ack_i),
  .pin_o    (pin_o),
  .done_o   (done_o),
  .busy_o   (busy_o)
);

// File: tb/pulse_burst_gen_tb.sv
module pulse_burst_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, mode = 1'b0;
  logic x_load = 1'b0, y_load = 1'b0, restart = 1'b0, ack = 1'b0;
  logic [W-1:0] x_data = '0, y_data = '0;
  logic pin, done, busy;

  int cyc = 0, checks = 0, fails = 0;
  int ex = 0, xeff = 1;
  bit lvl = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_burst_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .x_load_i(x_load), .x_i(x_data), .y_load_i(y_load), .y_i(y_data),
    .restart_i(restart), .ack_i(ack),
    .pin_o(pin), .done_o(done), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // tasks are entered just after a falling edge
  task automatic load_x(input int x);
    x_load = 1'b1;
    x_data = W'(x);
    ex     = cyc + 1;
    xeff   = (x == 0) ? 65536 : x;
    @(negedge clk);
    x_load = 1'b0;
  endtask

  function automatic int first_roll(input int ey, input bit rs);
    if (rs) return ey + xeff;
    return ex + ((ey - ex) / xeff + 1) * xeff;
  endfunction

  // wr2 < 0: no second write; else second write issued wr2 cycles after start (pulse only)
  task automatic run(input string req, input int x, input int y, input bit md,
                     input int gap, input bit rs, input int wr2, input int y2);
    int ey, s, f, wr2_abs, ey2, s2;
    int bad_pin, bad_busy, bad_done, exp_pin, exp_busy, exp_done, t, tt;
    bit ok_pin, ok_busy, ok_done;
    mode = md;
    load_x(x);
    repeat (gap) @(negedge clk);
    ey = cyc + 1;
    y_load = 1'b1;
    y_data = W'(y);
    restart = rs;
    s = first_roll(ey, rs);
    if (rs) ex = ey;
    wr2_abs = -10;
    if (wr2 >= 0) begin
      wr2_abs = s + wr2;
      ey2 = wr2_abs + 1;
      s2 = first_roll(ey2, 1'b0);
      f = s2 + y2 * xeff;
    end else begin
      f = md ? s + (y - 1) * xeff : s + y * xeff;
    end
    @(negedge clk);
    y_load = 1'b0;
    restart = 1'b0;
    ok_pin = 1; ok_busy = 1; ok_done = 1;
    bad_pin = 0; bad_busy = 0; bad_done = 0;
    exp_pin = 0; exp_busy = 0; exp_done = 0;
    while (cyc <= f + 2) begin
      t = cyc;
      if (t == wr2_abs) begin
        y_load = 1'b1;
        y_data = W'(y2);
      end else begin
        y_load = 1'b0;
      end
      if (t < s) exp_pin = lvl;
      else if (!md) exp_pin = (t < f) ? 1 : 0;
      else begin
        tt = (t < f) ? t : f;
        exp_pin = lvl ^ ((((tt - s) / xeff) + 1) & 1);
      end
      exp_busy = (t < f) ? 1 : 0;
      exp_done = (t >= f) ? 1 : 0;
      if (ok_pin && int'(pin) != exp_pin) begin ok_pin = 0; bad_pin = exp_pin; end
      if (ok_busy && int'(busy) != exp_busy) begin ok_busy = 0; bad_busy = exp_busy; end
      if (ok_done && int'(done) != exp_done) begin ok_done = 0; bad_done = exp_done; end
      @(negedge clk);
    end
    y_load = 1'b0;
    chk(ok_pin,  {req, " pin waveform"},  ok_pin  ? 0 : int'(!bad_pin[0]),  bad_pin);
    chk(ok_busy, "R5 busy window",         ok_busy ? 0 : int'(!bad_busy[0]), bad_busy);
    chk(ok_done, "R6 done edge",           ok_done ? 0 : int'(!bad_done[0]), bad_done);
    lvl = md ? (lvl ^ y[0]) : 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R6 done held", done, 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(done == 1'b0, "R6 ack clears", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int r;
    r = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(pin == 1'b0 && busy == 1'b0 && done == 1'b0, "R10 reset state",
        {pin, busy, done}, 0);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk(pin == 1'b0 && busy == 1'b0 && done == 1'b0, "R10 after release",
        {pin, busy, done}, 0);

    // R2 shortest pulse, R1 phase tracking
    run("R2 shortest", 1, 1, 1'b0, 0, 1'b0, -1, 0);
    run("R2 delayed start", 5, 3, 1'b0, 2, 1'b0, -1, 0);
    run("R1 phase follows x load", 7, 2, 1'b0, 9, 1'b0, -1, 0);
    // R4 restart
    run("R4 restart", 5, 2, 1'b0, 2, 1'b1, -1, 0);
    // R3 toggle leaves level high, then a burst from the high level
    run("R3 toggle odd", 3, 3, 1'b1, 1, 1'b0, -1, 0);
    chk(pin == 1'b1, "R3 level held", pin, 1);
    run("R3 toggle from high", 2, 2, 1'b1, 0, 1'b0, -1, 0);
    run("R3 toggle back low", 2, 1, 1'b1, 3, 1'b1, -1, 0);
    // R7 retrigger during a pulse
    run("R7 retrigger", 4, 3, 1'b0, 1, 1'b0, 5, 2);

    // R8 zero count is ignored
    mode = 1'b0;
    load_x(2);
    y_load = 1'b1; y_data = '0;
    @(negedge clk);
    y_load = 1'b0;
    repeat (8) @(negedge clk);
    chk(busy == 1'b0 && pin == lvl && done == 1'b0, "R8 zero count ignored",
        {pin, busy, done}, {lvl, 2'b00});

    // R9 disable during a toggle burst
    begin
      int ey, s;
      mode = 1'b1;
      load_x(3);
      ey = cyc + 1;
      y_load = 1'b1; y_data = W'(6);
      s = first_roll(ey, 1'b0);
      @(negedge clk);
      y_load = 1'b0;
      while (cyc < s) @(negedge clk);
      chk(pin == ~lvl, "R9 burst running before disable", pin, ~lvl);
      en = 1'b0;
      @(negedge clk);
      chk(pin == 1'b0 && busy == 1'b0 && done == 1'b0, "R9 disable clears",
          {pin, busy, done}, 0);
      y_load = 1'b1; y_data = W'(2);
      @(negedge clk);
      y_load = 1'b0;
      repeat (10) @(negedge clk);
      chk(pin == 1'b0 && busy == 1'b0, "R9 write ignored while disabled",
          {pin, busy}, 0);
      en = 1'b1;
      lvl = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R9 nothing pending after enable", busy, 0);
    end

    // random mix
    for (int i = 0; i < 24; i++) begin
      int rx, ry, rg;
      bit rm, rr;
      rx = 1 + int'($urandom % 6);
      ry = 1 + int'($urandom % 5);
      rg = int'($urandom % 9);
      rm = 1'($urandom % 2);
      rr = 1'($urandom % 2);
      run(rm ? "R3 random" : "R2 random", rx, ry, rm, rg, rr, -1, 0);
    end

    // R1 zero period means 65536 clocks
    run("R1 zero period", 0, 1, 1'b1, 0, 1'b1, -1, 0);

    finish_run();
  end
endmodule